// File: doc/BRIEF.md
# Link Training Status Monitor

This block sits between a register port and a link layer. Software uses it to start link training and to follow the result. Writing the enable bit sets the enable output to the link layer. The block then watches the training state input until the low five bits show the operational code 0x11. A millisecond tick input counts a timeout window while it waits.

Reaching the operational code sets a sticky done flag. After a fixed settle interval, measured in clock cycles, the ready output rises. If the window runs out first, a sticky timeout flag is set instead. Either sticky flag drives the interrupt output.

The block also holds the target link speed. It keeps this value in two mirrored registers, and the speed field can be changed only while an unlock bit is set. A read-only status word reports the live speed, width and training state.

Top module: `lnk_train_mon`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, UNLOCK (address 1) reads 0, both speed copies (addresses 2 and 3) read 2, and train_en_o, ready_o and irq_o are low.
- R2: Writing CTRL bit 0 from 0 to 1 starts training and raises train_en_o on the next cycle. Writing 1 while it is already 1 does not restart, so a ready link stays ready.
- R3: During training, a training state whose low 5 bits equal 0x11 sets the done flag (CTRL bit 1) and irq_o on the following cycle. The upper bits of the state input are ignored, and any other code does not set done.
- R4: ready_o and CTRL bit 3 rise exactly CLK_PER_US*SETTLE_US cycles after done is set, with no earlier rise.
- R5: While training is waiting for the link, the TIMEOUT_MS-th tick sets the timeout flag (CTRL bit 2) and irq_o. Fewer ticks leave it clear.
- R6: If the state is already 0x11 when training is enabled, done and ready are both set on the cycle after the write, with no settle wait.
- R7: The done and timeout flags stay set until software writes 1 to their own bit in CTRL. Writing 0 there leaves them set, and CTRL bit 3 cannot be written.
- R8: The tick count restarts from zero each time training is enabled again.
- R9: A write to the speed field at address 2 takes effect only while UNLOCK bit 0 is 1. At any other time it is ignored.
- R10: An accepted speed write updates both copies and tgt_speed_o together. Writes to address 3 are ignored.
- R11: Only the speed codes 1, 2 and 3 are accepted. Any other code leaves the speed unchanged.
- R12: The status word at address 4 holds the link speed in bits 19:16, the link width in bits 23:20 and the raw training state in bits 5:0. All other bits are 0.
- R13: Writing CTRL bit 0 to 0 drops train_en_o and ready_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| ltssm_i | input | 6 | Training state from the link layer |
| link_speed_i | input | 4 | Negotiated speed code |
| link_width_i | input | 4 | Negotiated lane count |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| train_en_o | output | 1 | Training enable to the link layer |
| tgt_speed_o | output | 4 | Target speed code to the link layer |
| link_up_o | output | 1 | Training state is the operational code |
| ready_o | output | 1 | Link up and settle interval elapsed |
| irq_o | output | 1 | Done or timeout flag set |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one cycle. The done flag or the ready output then fails to follow the operational code, or the flags fail to follow a disable. Counter faults show up only at the boundaries. If the tick counter is off by one, the timeout flag moves between the 99th and the 100th tick. If the settle counter is off by one, ready_o moves by a cycle around the settle limit. The bench therefore samples both counters on the cycle before their limit and on the cycle at it. A fault in the write gate shows up on the next read of either speed copy, or right away on tgt_speed_o.

// File: rtl/ltm_pkg.sv
package ltm_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_UNLK = 3'd1;
  localparam logic [AW-1:0] A_CAP  = 3'd2;
  localparam logic [AW-1:0] A_CTL2 = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TRAIN,
    S_SETTLE,
    S_UP,
    S_FAIL
  } seq_state_e;
endpackage

// File: rtl/ltm_status.sv
module ltm_status #(
  parameter int STATE_W = 6,
  parameter int CODE_W  = 5,
  parameter int UP_CODE = 'h11,
  parameter int SPD_W   = 4,
  parameter int WID_W   = 4
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [SPD_W-1:0]   speed_i,
  input  logic [WID_W-1:0]   width_i,
  output logic               link_up_o,
  output logic [31:0]        status_o
);
  localparam logic [CODE_W-1:0] UP = CODE_W'(UP_CODE);

  assign link_up_o = (state_i[CODE_W-1:0] == UP);

  always_comb begin
    status_o = '0;
    status_o[STATE_W-1:0] = state_i;
    status_o[16 +: SPD_W] = speed_i;
    status_o[20 +: WID_W] = width_i;
  end
endmodule

// File: rtl/ltm_seq.sv
module ltm_seq
  import ltm_pkg::*;
#(
  parameter int TIMEOUT_MS = 100,
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic link_up_i,
  input  logic tick_i,
  output logic set_done_o,
  output logic set_to_o,
  output logic ready_o
);
  localparam int MSW = $clog2(TIMEOUT_MS + 1);
  localparam int STW = $clog2(SETTLE_CYC + 1);
  localparam logic [MSW-1:0] MS_LAST = MSW'(TIMEOUT_MS - 1);
  localparam logic [STW-1:0] ST_LAST = STW'(SETTLE_CYC - 1);

  seq_state_e st_q, st_d;
  logic [MSW-1:0] ms_q;
  logic [STW-1:0] sc_q;

  always_comb begin
    st_d       = st_q;
    set_done_o = 1'b0;
    set_to_o   = 1'b0;
    if (stop_i) begin
      st_d = S_IDLE;
    end else if (start_i) begin
      if (link_up_i) begin
        st_d       = S_UP;
        set_done_o = 1'b1;
      end else begin
        st_d = S_TRAIN;
      end
    end else begin
      case (st_q)
        S_TRAIN: begin
          if (link_up_i) begin
            st_d       = S_SETTLE;
            set_done_o = 1'b1;
          end else if (tick_i && ms_q == MS_LAST) begin
            st_d     = S_FAIL;
            set_to_o = 1'b1;
          end
        end
        S_SETTLE: if (sc_q == ST_LAST) st_d = S_UP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      ms_q <= '0;
      sc_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_i) ms_q <= '0;
      else if (st_q == S_TRAIN && tick_i) ms_q <= ms_q + 1'b1;
      if (st_q == S_SETTLE) sc_q <= sc_q + 1'b1;
      else sc_q <= '0;
    end
  end

  assign ready_o = (st_q == S_UP);
endmodule

// File: rtl/ltm_regs.sv
module ltm_regs
  import ltm_pkg::*;
#(
  parameter int SPD_W   = 4,
  parameter int DEF_SPD = 2,
  parameter int MAX_GEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             set_done_i,
  input  logic             set_to_i,
  input  logic             ready_i,
  input  logic [31:0]      status_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic             start_o,
  output logic             stop_o,
  output logic [SPD_W-1:0] tgt_spd_o,
  output logic             flag_o
);
  logic en_q, done_q, to_q, unlk_q;
  logic [SPD_W-1:0] cap_q, ctl2_q;
  logic ctrl_wr, cap_ok;
  logic [SPD_W-1:0] spd_w;

  assign ctrl_wr = we_i && addr_i == A_CTRL;
  assign start_o = ctrl_wr && wdata_i[0] && !en_q;
  assign stop_o  = ctrl_wr && !wdata_i[0] && en_q;
  assign spd_w   = wdata_i[SPD_W-1:0];
  assign cap_ok  = we_i && addr_i == A_CAP && unlk_q &&
                   spd_w >= SPD_W'(1) && spd_w <= SPD_W'(MAX_GEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unlk_q <= 1'b0;
      cap_q  <= SPD_W'(DEF_SPD);
      ctl2_q <= SPD_W'(DEF_SPD);
    end else begin
      if (ctrl_wr) en_q <= wdata_i[0];
      done_q <= set_done_i | (done_q & ~(ctrl_wr & wdata_i[1]));
      to_q   <= set_to_i   | (to_q   & ~(ctrl_wr & wdata_i[2]));
      if (we_i && addr_i == A_UNLK) unlk_q <= wdata_i[0];
      if (cap_ok) begin
        cap_q  <= spd_w;
        ctl2_q <= spd_w;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[3:0] = {ready_i, to_q, done_q, en_q};
      A_UNLK: rdata_o[0] = unlk_q;
      A_CAP:  rdata_o[SPD_W-1:0] = cap_q;
      A_CTL2: rdata_o[SPD_W-1:0] = ctl2_q;
      A_STAT: rdata_o = status_i;
      default: ;
    endcase
  end

  assign en_o      = en_q;
  assign tgt_spd_o = cap_q;
  assign flag_o    = done_q | to_q;
endmodule

// File: rtl/lnk_train_mon.sv
module lnk_train_mon #(
  parameter int STATE_W    = 6,
  parameter int CODE_W     = 5,
  parameter int UP_CODE    = 'h11,
  parameter int SPD_W      = 4,
  parameter int WID_W      = 4,
  parameter int DEF_SPD    = 2,
  parameter int MAX_GEN    = 3,
  parameter int TIMEOUT_MS = 100,
  parameter int CLK_PER_US = 100,
  parameter int SETTLE_US  = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [STATE_W-1:0] ltssm_i,
  input  logic [SPD_W-1:0]   link_speed_i,
  input  logic [WID_W-1:0]   link_width_i,
  input  logic               tick_ms_i,
  output logic               train_en_o,
  output logic [SPD_W-1:0]   tgt_speed_o,
  output logic               link_up_o,
  output logic               ready_o,
  output logic               irq_o
);
  localparam int SETTLE_CYC = CLK_PER_US * SETTLE_US;

  logic start, stop, set_done, set_to, rdy;
  logic [31:0] status;

  ltm_status #(
    .STATE_W(STATE_W), .CODE_W(CODE_W), .UP_CODE(UP_CODE),
    .SPD_W(SPD_W), .WID_W(WID_W)
  ) u_status (
    .state_i  (ltssm_i),
    .speed_i  (link_speed_i),
    .width_i  (link_width_i),
    .link_up_o(link_up_o),
    .status_o (status)
  );

  ltm_seq #(
    .TIMEOUT_MS(TIMEOUT_MS), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .link_up_i (link_up_o),
    .tick_i    (tick_ms_i),
    .set_done_o(set_done),
    .set_to_o  (set_to),
    .ready_o   (rdy)
  );

  ltm_regs #(
    .SPD_W(SPD_W), .DEF_SPD(DEF_SPD), .MAX_GEN(MAX_GEN)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .set_done_i(set_done),
    .set_to_i  (set_to),
    .ready_i   (rdy),
    .status_i  (status),
    .rdata_o   (reg_rdata_o),
    .en_o      (train_en_o),
    .start_o   (start),
    .stop_o    (stop),
    .tgt_spd_o (tgt_speed_o),
    .flag_o    (irq_o)
  );

  assign ready_o = rdy;
endmodule

// File: rtl/ltm_chk.sv
module ltm_chk #(
  parameter int SPD_W   = 4,
  parameter int MAX_GEN = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic             train_en_o,
  input logic             ready_o,
  input logic             irq_o,
  input logic [SPD_W-1:0] tgt_speed_o
);
  a_r4_ready_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> train_en_o);

  a_r13_off_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(train_en_o) |-> !ready_o);

  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_addr_i == ltm_pkg::A_CTRL)) |=> irq_o);

  a_r9_speed_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == ltm_pkg::A_CAP) |=> $stable(tgt_speed_o));

  a_r11_speed_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_speed_o >= SPD_W'(1)) && (tgt_speed_o <= SPD_W'(MAX_GEN)));
endmodule

bind lnk_train_mon ltm_chk #(.SPD_W(SPD_W), .MAX_GEN(MAX_GEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .train_en_o (train_en_o),
  .ready_o    (ready_o),
  .irq_o      (irq_o),
  .tgt_speed_o(tgt_speed_o)
);

// File: tb/lnk_train_mon_test.sv
`timescale 1ns/1ps
module lnk_train_mon_test;
  localparam int SETTLE = 100 * 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0] ltssm = 6'h00;
  logic [3:0] spd = 4'h0, wid = 4'h0;
  logic tick = 1'b0;
  logic train_en, link_up, ready, irq;
  logic [3:0] tgt;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  lnk_train_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ltssm_i(ltssm),
    .link_speed_i(spd), .link_width_i(wid), .tick_ms_i(tick),
    .train_en_o(train_en), .tgt_speed_o(tgt), .link_up_o(link_up),
    .ready_o(ready), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 3'd0, 32'h0);
    rd_chk("R1 unlock", 3'd1, 32'h0);
    rd_chk("R1 cap", 3'd2, 32'h2);
    rd_chk("R1 ctl2", 3'd3, 32'h2);
    chk("R1 outputs", {train_en, ready, irq}, 32'h0);
  endtask

  task automatic t_status;
    ltssm = 6'h25; spd = 4'h3; wid = 4'h4;
    rd_chk("R12 status", 3'd4, 32'h0043_0025);
    spd = 4'h1; wid = 4'h8; ltssm = 6'h11;
    rd_chk("R12 status2", 3'd4, 32'h0081_0011);
    ltssm = 6'h00;
  endtask

  task automatic t_cap;
    wr(3'd2, 32'h3);
    rd_chk("R9 locked write", 3'd2, 32'h2);
    wr(3'd1, 32'h1);
    wr(3'd2, 32'h3);
    rd_chk("R10 cap", 3'd2, 32'h3);
    rd_chk("R10 ctl2 mirror", 3'd3, 32'h3);
    chk("R10 tgt out", tgt, 32'h3);
    wr(3'd3, 32'h1);
    rd_chk("R10 ctl2 ro", 3'd3, 32'h3);
    wr(3'd2, 32'h5);
    rd_chk("R11 code 5", 3'd2, 32'h3);
    wr(3'd2, 32'h0);
    rd_chk("R11 code 0", 3'd2, 32'h3);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h1);
    rd_chk("R9 relocked", 3'd2, 32'h3);
    chk("R9 tgt held", tgt, 32'h3);
  endtask

  task automatic t_train_up;
    ltssm = 6'h03;
    wr(3'd0, 32'h1);
    chk("R2 train_en", train_en, 32'h1);
    ltssm = 6'h10;
    @(negedge clk);
    rd_chk("R3 wrong code", 3'd0, 32'h1);
    ltssm = 6'h31;
    @(negedge clk);
    rd_chk("R3 done set", 3'd0, 32'h3);
    chk("R3 irq", irq, 32'h1);
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 before settle", ready, 32'h0);
    @(negedge clk);
    chk("R4 at settle", ready, 32'h1);
    rd_chk("R4 ctrl ready", 3'd0, 32'hB);
    wr(3'd0, 32'h1);
    chk("R2 no restart", ready, 32'h1);
    wr(3'd0, 32'h9);
    rd_chk("R7 write 0 keeps", 3'd0, 32'hB);
    wr(3'd0, 32'h3);
    rd_chk("R7 clear done", 3'd0, 32'h9);
    chk("R7 irq clear", irq, 32'h0);
    wr(3'd0, 32'h0);
    chk("R13 ready drop", {train_en, ready}, 32'h0);
    ltssm = 6'h00;
  endtask

  task automatic t_timeout;
    ltssm = 6'h02;
    wr(3'd0, 32'h1);
    ticks(99);
    rd_chk("R5 99 ticks", 3'd0, 32'h1);
    ticks(1);
    rd_chk("R5 100 ticks", 3'd0, 32'h5);
    chk("R5 irq", irq, 32'h1);
    wr(3'd0, 32'h1);
    rd_chk("R7 timeout kept", 3'd0, 32'h5);
    wr(3'd0, 32'h5);
    rd_chk("R7 timeout clear", 3'd0, 32'h1);
  endtask

  task automatic t_restart;
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h1);
    ticks(50);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h1);
    ticks(99);
    rd_chk("R8 count restarted", 3'd0, 32'h1);
    ticks(1);
    rd_chk("R8 full window", 3'd0, 32'h5);
    wr(3'd0, 32'h4);
    rd_chk("R13 off", 3'd0, 32'h0);
  endtask

  task automatic t_already_up;
    ltssm = 6'h11;
    @(negedge clk);
    chk("R6 link_up", link_up, 32'h1);
    wr(3'd0, 32'h1);
    rd_chk("R6 instant ready", 3'd0, 32'hB);
    chk("R6 ready out", ready, 32'h1);
    wr(3'd0, 32'h2);
    rd_chk("R13 cleared", 3'd0, 32'h0);
    chk("R13 outputs", {train_en, ready}, 32'h0);
  endtask

  initial begin
    #1_500_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_cap();
    t_train_up();
    t_timeout();
    t_restart();
    t_already_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule